// File: doc/BRIEF.md
# Gated Pulse Accumulator

A 16-bit accumulator that counts activity on one external input pin. It has two modes, chosen by a mode bit in its control register. In event mode it counts edges of one polarity on the pin. In gated mode it counts ticks of a shared divide-by-64 timebase for as long as the pin stays at a chosen active level. When the pin leaves that level, the block raises an input flag that marks the end of the interval. A wrap of the counter raises a separate overflow flag. Each flag drives its own active-high interrupt line through an enable bit.

The pin passes through a two-stage synchronizer before anything uses it. A small state machine tracks the gate: `ST_EVENT` in event mode, `ST_SHUT` in gated mode with the pin inactive, and `ST_OPEN` in gated mode with the pin active. It moves as follows:
- `T_TO_EVENT`: from any state to `ST_EVENT` when the mode bit is clear.
- `T_OPEN`: from `ST_EVENT` or `ST_SHUT` to `ST_OPEN` when the mode bit is set and the level is active.
- `T_SHUT`: from `ST_EVENT` or `ST_OPEN` to `ST_SHUT` when the mode bit is set and the level is inactive.

`T_SHUT` taken from `ST_OPEN` is the trailing edge, and it sets the input flag.

Software uses a synchronous register port with one shared address for read and write. The control register is at address 0, the counter at address 1 and the flags at address 2. Address 3 reads as zero.

Top module: `gate_accum`

## Requirements
- R1: After reset, the counter, both flags, every control bit and both interrupt lines are zero, and all three registers read 0.
- R2: A write to address 0 loads the control bits: bit0 selects the mode (1 = gated), bit1 is the polarity, bit2 enables the input interrupt and bit3 enables the overflow interrupt. A write to address 1 loads the counter on that clock edge. Address 2 reads the input flag in bit0 and the overflow flag in bit1.
- R3: In event mode the counter adds one for each rising edge of the pin when polarity is 0, or each falling edge when polarity is 1. This holds whatever the state of timer_en. An edge is counted at the third clock edge after the pin changes, because of the two-stage synchronizer.
- R4: In gated mode the counter adds one on each cycle that has tick64 high, timer_en high and the synchronized pin at its active level. The active level is high when polarity is 0 and low when polarity is 1.
- R5: In gated mode, while timer_en is low, the counter does not change unless it is written.
- R6: In gated mode, a move of the synchronized pin from active to inactive (state `ST_OPEN` to `ST_SHUT`) sets the input flag. Edges in event mode never set it.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag.
- R8: Writing a 1 to a flag bit at address 2 clears that flag, and writing a 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R9: irq_in is high exactly when the input flag and its enable are both 1. irq_ovf is high exactly when the overflow flag and its enable are both 1.
- R10: A counter write in the same cycle as an increment loads the written value and does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| pin_in | input | 1 | External input pin (asynchronous) |
| timer_en | input | 1 | Main timer enable |
| tick64 | input | 1 | Divide-by-64 timebase tick from the shared prescaler |
| irq_in | output | 1 | Input-flag interrupt, active high |
| irq_ovf | output | 1 | Overflow interrupt, active high |

## Verification
Event mode is driven with steady edge trains of both polarities while timer_en is held low. This separates counting that depends on the edge from counting that depends on the timebase. Gated mode is driven with the pin held active while tick64 and timer_en switch independently. The pin is then dropped, which separates counting by level from counting by edge and shows the flag that comes from the trailing edge. Random runs then mix pin toggles, ticks, mode and polarity changes, counter preloads near 0xFFFF and flag clears. Over these runs a bench model checks wraps, races between set and clear, and races between a write and an increment.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        ST_EVENT = 2'd0,
        ST_SHUT  = 2'd1,
        ST_OPEN  = 2'd2
    } gate_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam int FB_IN  = 0;
    localparam int FB_OVF = 1;

    typedef struct packed {
        logic ie_ovf;
        logic ie_in;
        logic pol;
        logic mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic prev
);
    logic [STAGES-1:0] sr;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sr[0] <= 1'b0;
                else        sr[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sr[i] <= 1'b0;
                else        sr[i] <= sr[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sr[STAGES-1];
    end

    assign lvl = sr[STAGES-1];
endmodule

// File: rtl/pa_gate_fsm.sv
module pa_gate_fsm
    import pa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic pol,
    input  logic lvl,
    input  logic prev,
    input  logic tick,
    input  logic ten,
    output logic count_en,
    output logic trail,
    output logic gate_open
);
    gate_state_e state_q, state_d;
    logic active, evt;

    assign active = lvl ^ pol;
    assign evt    = pol ? (!lvl && prev) : (lvl && !prev);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EVENT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        count_en  = 1'b0;
        trail     = 1'b0;
        gate_open = 1'b0;
        unique case (state_q)
            ST_EVENT: begin
                count_en = mode ? (tick && ten && active) : evt;
                if (mode) state_d = active ? ST_OPEN : ST_SHUT;
            end
            ST_SHUT: begin
                count_en = mode ? (tick && ten && active) : evt;
                if (!mode)       state_d = ST_EVENT;
                else if (active) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                gate_open = 1'b1;
                count_en  = mode ? (tick && ten && active) : evt;
                if (!mode) begin
                    state_d = ST_EVENT;
                end else if (!active) begin
                    state_d = ST_SHUT;
                    trail   = 1'b1;
                end
            end
            default: state_d = ST_EVENT;
        endcase
    end
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    assign wrap = inc && !load && (&cnt);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (load) cnt <= ld_val;
        else if (inc)  cnt <= cnt + ONE;
    end
endmodule

// File: rtl/gate_accum.sv
module gate_accum
    import pa_pkg::*;
#(
    parameter int W          = 16,
    parameter int SYNC_STAGE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         pin_in,
    input  logic         timer_en,
    input  logic         tick64,
    output logic         irq_in,
    output logic         irq_ovf
);
    ctrl_t        ctrl_q;
    logic         flag_in_q, flag_ovf_q;
    logic         lvl, prev, inc_w, trail_w, open_w, wrap_w;
    logic [W-1:0] cnt_q;
    logic         wr_ctrl, wr_cnt, wr_flag;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_cnt  = reg_wr && (reg_addr == ADDR_CNT);
    assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);

    pa_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in), .lvl(lvl), .prev(prev)
    );

    pa_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .pol(ctrl_q.pol),
        .lvl(lvl), .prev(prev), .tick(tick64), .ten(timer_en),
        .count_en(inc_w), .trail(trail_w), .gate_open(open_w)
    );

    pa_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .ld_val(reg_wdata),
        .inc(inc_w), .cnt(cnt_q), .wrap(wrap_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_in_q  <= 1'b0;
            flag_ovf_q <= 1'b0;
        end else begin
            flag_in_q  <= (flag_in_q  && !(wr_flag && reg_wdata[FB_IN]))  || trail_w;
            flag_ovf_q <= (flag_ovf_q && !(wr_flag && reg_wdata[FB_OVF])) || wrap_w;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_CNT:  reg_rdata = cnt_q;
            ADDR_FLAG: begin
                reg_rdata[FB_IN]  = flag_in_q;
                reg_rdata[FB_OVF] = flag_ovf_q;
            end
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_in  = flag_in_q  && ctrl_q.ie_in;
    assign irq_ovf = flag_ovf_q && ctrl_q.ie_ovf;
endmodule

// File: rtl/pa_checker.sv
module pa_checker
    import pa_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic         timer_en,
    input ctrl_t        ctrl_q,
    input logic [W-1:0] cnt_q,
    input logic         flag_in_q,
    input logic         flag_ovf_q,
    input logic         wrap_w,
    input logic         trail_w
);
    logic wr_cnt;
    assign wr_cnt = reg_wr && (reg_addr == ADDR_CNT);

    // R10
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_q == $past(reg_wdata));
    // R5
    a_r5_gated_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode && !timer_en && !wr_cnt) |=> $stable(cnt_q));
    // R7
    a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_w |=> (cnt_q == '0) && flag_ovf_q);
    // R6
    a_r6_trail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trail_w |=> flag_in_q);
    // R8
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_in_q && !(reg_wr && reg_addr == ADDR_FLAG && reg_wdata[FB_IN])) |=> flag_in_q);
    // R3
    a_r3_event_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.mode && !wr_cnt) |=> (cnt_q == $past(cnt_q)) || (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

bind gate_accum pa_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .timer_en(timer_en), .ctrl_q(ctrl_q),
    .cnt_q(cnt_q), .flag_in_q(flag_in_q), .flag_ovf_q(flag_ovf_q),
    .wrap_w(wrap_w), .trail_w(trail_w)
);

// File: tb/gate_accum_bench.sv
module gate_accum_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         pin_in = 1'b0, timer_en = 1'b0, tick64 = 1'b0;
    logic         irq_in, irq_ovf;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gate_accum u_gate_accum (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .timer_en(timer_en), .tick64(tick64), .irq_in(irq_in), .irq_ovf(irq_ovf)
    );

    // reference model, from the requirements
    logic         m_s1, m_s2, m_p, m_open;
    logic         m_mode, m_pol, m_iei, m_ieo, m_fin, m_fov;
    logic [W-1:0] m_cnt;

    function automatic logic f_active(input logic s, input logic pol);
        return pol ? !s : s;
    endfunction

    function automatic logic f_evt(input logic s, input logic p, input logic pol);
        return pol ? (!s && p) : (s && !p);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_p = 0; m_open = 0;
            m_mode = 0; m_pol = 0; m_iei = 0; m_ieo = 0;
            m_fin = 0; m_fov = 0; m_cnt = '0;
        end else begin
            logic act, inc, trl, ovf;
            act = f_active(m_s2, m_pol);
            inc = m_mode ? (tick64 && timer_en && act) : f_evt(m_s2, m_p, m_pol);
            trl = m_mode && m_open && !act;
            ovf = 0;
            if (reg_wr && reg_addr == 2'd1) m_cnt = reg_wdata;
            else if (inc) begin
                ovf = (m_cnt == 16'hFFFF);
                m_cnt = m_cnt + 1'b1;
            end
            m_fin = (m_fin && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) || trl;
            m_fov = (m_fov && !(reg_wr && reg_addr == 2'd2 && reg_wdata[1])) || ovf;
            m_open = m_mode && act;
            if (reg_wr && reg_addr == 2'd0) begin
                m_mode = reg_wdata[0]; m_pol = reg_wdata[1];
                m_iei = reg_wdata[2]; m_ieo = reg_wdata[3];
            end
            m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare outputs against the model (call away from posedge)
    task automatic cmp_model();
        chk("R9 irq_in", {15'd0, irq_in}, {15'd0, m_fin && m_iei});
        chk("R9 irq_ovf", {15'd0, irq_ovf}, {15'd0, m_fov && m_ieo});
        case (reg_addr)
            2'd0: chk("R2 ctrl read", reg_rdata, {12'd0, m_ieo, m_iei, m_pol, m_mode});
            2'd1: chk("R3/R4 counter", reg_rdata, m_cnt);
            2'd2: chk("R8 flags", reg_rdata, {14'd0, m_fov, m_fin});
            default: chk("R2 unused addr", reg_rdata, '0);
        endcase
    endtask

    task automatic step(input logic pin, input logic tk, input logic ten,
                        input logic wr, input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        cmp_model();
        pin_in = pin; tick64 = tk; timer_en = ten;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle(input logic pin, input logic tk, input logic ten, input int n);
        for (int i = 0; i < n; i++) step(pin, tk, ten, 1'b0, 2'd1, '0);
    endtask

    task automatic rd(input logic [1:0] a);
        step(pin_in, 1'b0, timer_en, 1'b0, a, '0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        while (!done && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a));
            chk("R1 reset read", reg_rdata, '0);
        end
        chk("R1 irq reset", {14'd0, irq_in, irq_ovf}, '0);

        // R3 event mode, rising edges, timer disabled
        step(0, 0, 0, 1, 2'd0, 16'h000C);
        for (int k = 0; k < 5; k++) begin
            idle(1, 0, 0, 3);
            idle(0, 0, 0, 3);
        end
        idle(0, 0, 0, 4);
        rd(2'd1);
        chk("R3 rising count ten=0", reg_rdata, 16'd5);
        // R3 falling edges with polarity 1
        step(0, 0, 0, 1, 2'd0, 16'h000E);
        for (int k = 0; k < 3; k++) begin
            idle(1, 0, 0, 3);
            idle(0, 0, 0, 3);
        end
        idle(0, 0, 0, 4);
        rd(2'd1);
        chk("R3 falling count", reg_rdata, 16'd8);
        rd(2'd2);
        chk("R6 no flag in event mode", reg_rdata, '0);

        // R7/R2 preload and wrap
        step(0, 0, 0, 1, 2'd1, 16'hFFFE);
        idle(1, 0, 0, 3);
        idle(0, 0, 0, 3);
        idle(1, 0, 0, 3);
        idle(0, 0, 0, 4);
        rd(2'd1);
        chk("R7 wrap to zero", reg_rdata, 16'h0000);
        rd(2'd2);
        chk("R7 ovf flag", reg_rdata, 16'h0002);
        chk("R9 irq_ovf on", {15'd0, irq_ovf}, 16'd1);
        step(0, 0, 0, 1, 2'd2, 16'h0002);
        rd(2'd2);
        chk("R8 w1c ovf", reg_rdata, 16'h0000);

        // gated mode, polarity 0 (active high)
        step(0, 0, 0, 1, 2'd0, 16'h000D);
        step(0, 0, 0, 1, 2'd1, 16'h0000);
        idle(1, 1, 0, 8);
        rd(2'd1);
        chk("R5 stall ten=0", reg_rdata, 16'h0000);
        idle(1, 1, 1, 6);
        idle(1, 0, 1, 3);
        rd(2'd1);
        chk("R4 gated count", reg_rdata, 16'd6);
        idle(0, 0, 1, 4);
        rd(2'd2);
        chk("R6 trailing flag", reg_rdata, 16'h0001);
        chk("R9 irq_in on", {15'd0, irq_in}, 16'd1);
        idle(0, 1, 1, 5);
        rd(2'd1);
        chk("R4 inactive no count", reg_rdata, 16'd6);

        // R8 set wins: preload FFFF, wrap while clearing ovf
        idle(1, 0, 1, 4);
        step(1, 0, 1, 1, 2'd1, 16'hFFFF);
        step(1, 1, 1, 1, 2'd2, 16'h0002);
        rd(2'd2);
        chk("R8 set wins over clear", reg_rdata[1], 1'b1);
        // R10 write beats increment
        step(1, 1, 1, 1, 2'd1, 16'h1234);
        rd(2'd1);
        chk("R10 write wins", reg_rdata, 16'h1234);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            logic pin, tk, ten, wr;
            logic [1:0] a;
            logic [W-1:0] d;
            pin = ($urandom_range(0, 5) == 0) ? !pin_in : pin_in;
            tk  = ($urandom_range(0, 2) == 0);
            ten = ($urandom_range(0, 9) != 0);
            wr  = ($urandom_range(0, 11) == 0);
            a   = 2'($urandom_range(0, 3));
            d   = 16'($urandom);
            if (wr && a == 2'd1 && $urandom_range(0, 1) == 1) d = 16'hFFF0 | 16'($urandom_range(0, 15));
            if (wr && a == 2'd0) d = d & 16'h000F;
            if (!wr) a = 2'($urandom_range(0, 2));
            step(pin, tk, ten, wr, a, d);
        end
        @(negedge clk);
        cmp_model();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule